// File: doc/BRIEF.md
# Serial ADC Command and Conversion-Mode Controller

This block is the digital control side of a four-channel serial converter interface. It receives 8-bit command words on a serial data line framed by an active-low select and a serial clock. It sorts each word into one of two kinds. A channel-setup word writes a per-channel range code and input type. A mode word changes the operating mode or the power state. All three serial inputs are brought into the system clock domain, and every timing decision is made on their detected edges.

A sequencer places the sample instant for each conversion mode. In external-clock mode it follows a serial clock falling edge. In external-acquisition mode it follows a later serial clock falling edge. In internal-clock mode it is counted in pulses of a modelled internal conversion clock. That clock is an enable pulse from a divider on the system clock, started after a set delay. When a conversion ends, the end-of-conversion strobe goes high and the output bit shows the first bit of the captured result. Partial power-down is left only on a recognised mode word, never on select activity alone.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: A word begins at the first 1 sampled on a rising serial clock edge while select is low; zeros before it are skipped. The word is eight bits, MSB first, start bit included. Raising select before the eighth bit discards the partial word.
- R2: A word whose bits [3:0] are 1000 is a mode word with code M = bits [6:4]. Any other word is a setup word: bits [6:4] pick the channel (0..3 valid, 4..7 ignored), bits [3:1] are the range code, and bit 0 is 1 for differential and 0 for single-ended.
- R3: Mode codes 000, 001 and 010 select external-clock (0), external-acquisition (1) and internal-clock (2) mode and clear any power-down. Codes 011 and 101 change nothing. The reported mode is always 0, 1 or 2.
- R4: Code 100 and the asynchronous reset both restore defaults: mode 0, no power-down, and every channel set to range 001, single-ended.
- R5: Code 110 enters partial power-down. Only codes 000, 001, 010, 100 and 111 leave it. Select toggling, partial words, setup words and codes 011, 101 and 110 do not. A setup word in power-down still updates its channel and leaves the mode unchanged. Partial and full power-down are never both set.
- R6: Code 111 enters full power-down. In either power-down state a setup word starts no conversion, so no sample pulse and no internal clock pulse occur.
- R7: In mode 0, a setup word gives one sample pulse after the falling edge of its 8th serial clock and none before. The strobe stays low in mode 0.
- R8: In mode 1, the sample pulse follows the falling edge of the 16th serial clock counted from the start bit, and none comes after the 15th. If select rises before the 16th, no sample occurs.
- R9: In mode 2, the internal clock starts ICLK_DLY system cycles after the 8th falling edge and pulses every ICLK_DIV cycles. The sample pulse follows the 11th internal pulse, and select may rise after the 8th falling edge without stopping it.
- R10: In modes 1 and 2, the strobe rises after the CONV_TICKS-th internal pulse that follows the sample. At that point the output bit takes the MSB of the result input. The strobe stays high while select is low and falls on the rising serial clock edge of the next start bit.
- R11: Every sample pulse lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial command data |
| result_i | input | RES_W | Conversion result stub value |
| dout_o | output | 1 | First result bit, latched at end of conversion |
| sstrb_o | output | 1 | End-of-conversion strobe |
| sample_o | output | 1 | One-cycle sample-instant pulse |
| iclk_o | output | 1 | Internal conversion clock enable pulse |
| mode_o | output | 3 | Active conversion mode (0, 1 or 2) |
| part_pd_o | output | 1 | Partial power-down active |
| full_pd_o | output | 1 | Full power-down active |
| cfg_range_o | output | 3*N_CH | Range code per channel, channel 0 in the low bits |
| cfg_diff_o | output | N_CH | Differential flag per channel |

## Verification
A bit counter that slips shows up within one word. The word after it decodes as the wrong kind, so the mode, power flags or a channel field at the ports go wrong right after the select rises. A falling-edge or internal-pulse count that is off by one moves the sample pulse by one serial clock period or one divider period. The bench catches this by counting pulses around the expected edge. A sequencer stuck busy, or a power-down flag that clears too early, shows up on the next setup word as a missing or extra sample pulse, or a strobe that never rises.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

  typedef enum logic [2:0] {
    MC_EXT_CLK  = 3'b000,
    MC_EXT_ACQ  = 3'b001,
    MC_INT_CLK  = 3'b010,
    MC_SPARE_A  = 3'b011,
    MC_DEFAULTS = 3'b100,
    MC_SPARE_B  = 3'b101,
    MC_PART_PD  = 3'b110,
    MC_FULL_PD  = 3'b111
  } mode_code_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT_EDGE,
    SQ_ACQUIRE,
    SQ_CONVERT
  } seq_state_e;

  typedef struct packed {
    logic [2:0] range;
    logic       diff;
  } ch_cfg_t;

  localparam logic [3:0] MODE_WORD_TAIL = 4'b1000;

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/adc_word_rx.sv
module adc_word_rx #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_high_i,
  input  logic                 sclk_rise_i,
  input  logic                 din_i,
  output logic                 start_o,
  output logic                 word_vld_o,
  output logic [WORD_BITS-1:0] word_o
);

  localparam int CW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BITS - 1);

  logic                 busy_q, busy_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [WORD_BITS-2:0] shift_q, shift_d;
  logic                 start_q, start_d;
  logic                 vld_q, vld_d;
  logic [WORD_BITS-1:0] word_q, word_d;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    word_d  = word_q;
    start_d = 1'b0;
    vld_d   = 1'b0;
    if (cs_high_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (sclk_rise_i) begin
      if (!busy_q) begin
        if (din_i) begin
          busy_d  = 1'b1;
          cnt_d   = CW'(1);
          shift_d = {{(WORD_BITS-2){1'b0}}, 1'b1};
          start_d = 1'b1;
        end
      end else begin
        shift_d = {shift_q[WORD_BITS-3:0], din_i};
        if (cnt_q == LAST_IDX) begin
          word_d = {shift_q, din_i};
          vld_d  = 1'b1;
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      word_q  <= '0;
      start_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      word_q  <= word_d;
      start_q <= start_d;
      vld_q   <= vld_d;
    end
  end

  assign start_o    = start_q;
  assign word_vld_o = vld_q;
  assign word_o     = word_q;

endmodule

// File: rtl/adc_iclk_gen.sv
module adc_iclk_gen #(
  parameter int START_DLY = 25,
  parameter int DIV       = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int MAXC = (START_DLY > DIV) ? START_DLY : DIV;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(START_DLY - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!en_i) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q) begin
      if (cnt_q == DLY_LAST) begin
        run_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else if (cnt_q == DIV_LAST) begin
      tick_d = 1'b1;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_cmd_pkg::*;
#(
  parameter int EXTCLK_FALLS = 8,
  parameter int EXTACQ_FALLS = 16,
  parameter int INTCLK_FALLS = 8,
  parameter int ACQ_TICKS    = 11,
  parameter int CONV_TICKS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_code_e mode_i,
  input  logic       go_i,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic       cs_high_i,
  input  logic       cs_rise_i,
  input  logic       sclk_fall_i,
  input  logic       tick_i,
  output logic       sample_o,
  output logic       done_o,
  output logic       iclk_en_o
);

  localparam int MAXF = (EXTACQ_FALLS > INTCLK_FALLS) ?
                        ((EXTACQ_FALLS > EXTCLK_FALLS) ? EXTACQ_FALLS : EXTCLK_FALLS) :
                        ((INTCLK_FALLS > EXTCLK_FALLS) ? INTCLK_FALLS : EXTCLK_FALLS);
  localparam int FW   = $clog2(MAXF + 1);
  localparam int MAXT = (ACQ_TICKS > CONV_TICKS) ? ACQ_TICKS : CONV_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [FW-1:0] F_EXTCLK = FW'(EXTCLK_FALLS);
  localparam logic [FW-1:0] F_EXTACQ = FW'(EXTACQ_FALLS);
  localparam logic [FW-1:0] F_INTCLK = FW'(INTCLK_FALLS);
  localparam logic [TW-1:0] T_ACQ    = TW'(ACQ_TICKS);
  localparam logic [TW-1:0] T_CONV   = TW'(CONV_TICKS);

  seq_state_e    state_q, state_d;
  logic [FW-1:0] fcnt_q, fcnt_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          sample_q, sample_d;
  logic          done_q, done_d;
  logic [FW-1:0] fcnt_nx;
  logic [TW-1:0] tcnt_nx;
  logic [FW-1:0] target;
  logic          fall_hit;

  assign fcnt_nx = fcnt_q + FW'(1);
  assign tcnt_nx = tcnt_q + TW'(1);

  always_comb begin
    case (mode_i)
      MC_EXT_ACQ: target = F_EXTACQ;
      MC_INT_CLK: target = F_INTCLK;
      default:    target = F_EXTCLK;
    endcase
  end

  assign fall_hit = sclk_fall_i && !cs_high_i && (fcnt_nx == target);

  // Falling-edge count since the latest start bit, saturating.
  always_comb begin
    fcnt_d = fcnt_q;
    if (start_i) begin
      fcnt_d = '0;
    end else if (sclk_fall_i && !cs_high_i && (fcnt_q != '1)) begin
      fcnt_d = fcnt_nx;
    end
  end

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    sample_d = 1'b0;
    done_d   = 1'b0;
    if (abort_i) begin
      state_d = SQ_IDLE;
      tcnt_d  = '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (go_i) state_d = SQ_WAIT_EDGE;
        end
        SQ_WAIT_EDGE: begin
          if (cs_rise_i) begin
            state_d = SQ_IDLE;
          end else if (fall_hit) begin
            tcnt_d = '0;
            case (mode_i)
              MC_EXT_ACQ: begin
                sample_d = 1'b1;
                state_d  = SQ_CONVERT;
              end
              MC_INT_CLK: state_d = SQ_ACQUIRE;
              default: begin
                sample_d = 1'b1;
                state_d  = SQ_IDLE;
              end
            endcase
          end
        end
        SQ_ACQUIRE: begin
          if (tick_i) begin
            if (tcnt_nx == T_ACQ) begin
              sample_d = 1'b1;
              tcnt_d   = '0;
              state_d  = SQ_CONVERT;
            end else begin
              tcnt_d = tcnt_nx;
            end
          end
        end
        SQ_CONVERT: begin
          if (tick_i) begin
            if (tcnt_nx == T_CONV) begin
              done_d  = 1'b1;
              tcnt_d  = '0;
              state_d = SQ_IDLE;
            end else begin
              tcnt_d = tcnt_nx;
            end
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      fcnt_q   <= '0;
      tcnt_q   <= '0;
      sample_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      fcnt_q   <= fcnt_d;
      tcnt_q   <= tcnt_d;
      sample_q <= sample_d;
      done_q   <= done_d;
    end
  end

  assign sample_o  = sample_q;
  assign done_o    = done_q;
  assign iclk_en_o = (state_q == SQ_ACQUIRE) || (state_q == SQ_CONVERT);

endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int         N_CH       = 4,
  parameter int         RES_W      = 16,
  parameter int         ICLK_DLY   = 25,
  parameter int         ICLK_DIV   = 22,
  parameter int         CONV_TICKS = 16,
  parameter logic [2:0] DEF_RANGE  = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic              sstrb_o,
  output logic              sample_o,
  output logic              iclk_o,
  output logic [2:0]        mode_o,
  output logic              part_pd_o,
  output logic              full_pd_o,
  output logic [3*N_CH-1:0] cfg_range_o,
  output logic [N_CH-1:0]   cfg_diff_o
);

  localparam int WORD_BITS = 8;
  localparam ch_cfg_t CFG_DEFAULT = '{range: DEF_RANGE, diff: 1'b0};

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_ni = rst_sync_q;

  // Serial inputs into the clock domain, then edge detection.
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, din_s;
  logic       cs_q, sclk_q;
  logic       sclk_rise, sclk_fall, cs_rise;

  adc_in_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .async_i({cs_n_i, sclk_i, din_i}),
    .sync_o (pins_s)
  );
  assign {cs_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_rise   = cs_s & ~cs_q;

  // Word receiver
  logic                 start_p, word_vld;
  logic [WORD_BITS-1:0] word;

  adc_word_rx #(.WORD_BITS(WORD_BITS)) i_rx (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cs_high_i  (cs_s),
    .sclk_rise_i(sclk_rise),
    .din_i      (din_s),
    .start_o    (start_p),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  // Decode
  logic       is_mode, is_cfg, mode_act;
  mode_code_e mcode;
  logic [2:0] sel;

  assign mcode   = mode_code_e'(word[6:4]);
  assign sel     = word[6:4];
  assign is_mode = word_vld && word[7] && (word[3:0] == MODE_WORD_TAIL);
  assign is_cfg  = word_vld && word[7] && (word[3:0] != MODE_WORD_TAIL);
  assign mode_act = is_mode && (mcode != MC_SPARE_A) && (mcode != MC_SPARE_B);

  // Mode and power state
  mode_code_e mode_q, mode_d;
  logic       ppd_q, ppd_d, fpd_q, fpd_d;
  logic       cfg_restore;

  always_comb begin
    mode_d      = mode_q;
    ppd_d       = ppd_q;
    fpd_d       = fpd_q;
    cfg_restore = 1'b0;
    if (is_mode) begin
      case (mcode)
        MC_EXT_CLK, MC_EXT_ACQ, MC_INT_CLK: begin
          mode_d = mcode;
          ppd_d  = 1'b0;
          fpd_d  = 1'b0;
        end
        MC_DEFAULTS: begin
          mode_d      = MC_EXT_CLK;
          ppd_d       = 1'b0;
          fpd_d       = 1'b0;
          cfg_restore = 1'b1;
        end
        MC_PART_PD: begin
          ppd_d = 1'b1;
          fpd_d = 1'b0;
        end
        MC_FULL_PD: begin
          ppd_d = 1'b0;
          fpd_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MC_EXT_CLK;
      ppd_q  <= 1'b0;
      fpd_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ppd_q  <= ppd_d;
      fpd_q  <= fpd_d;
    end
  end

  // Per-channel setup registers
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ch_cfg_t cfg_q, cfg_d;
    logic    we;
    assign we = is_cfg && (sel == 3'(g));

    always_comb begin
      cfg_d = cfg_q;
      if (cfg_restore) begin
        cfg_d = CFG_DEFAULT;
      end else if (we) begin
        cfg_d = '{range: word[3:1], diff: word[0]};
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= CFG_DEFAULT;
      else         cfg_q <= cfg_d;
    end

    assign cfg_range_o[3*g +: 3] = cfg_q.range;
    assign cfg_diff_o[g]         = cfg_q.diff;
  end

  // Sequencer and internal clock
  logic go, tick, iclk_en, smp, conv_done;

  assign go = is_cfg && !ppd_q && !fpd_q;

  adc_iclk_gen #(.START_DLY(ICLK_DLY), .DIV(ICLK_DIV)) i_iclk (
    .clk   (clk),
    .rst_n (rst_ni),
    .en_i  (iclk_en),
    .tick_o(tick)
  );

  adc_conv_seq #(.CONV_TICKS(CONV_TICKS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_ni),
    .mode_i     (mode_q),
    .go_i       (go),
    .abort_i    (mode_act),
    .start_i    (start_p),
    .cs_high_i  (cs_s),
    .cs_rise_i  (cs_rise),
    .sclk_fall_i(sclk_fall),
    .tick_i     (tick),
    .sample_o   (smp),
    .done_o     (conv_done),
    .iclk_en_o  (iclk_en)
  );

  // End-of-conversion strobe and first output bit
  logic sstrb_q, sstrb_d, dbit_q, dbit_d;

  always_comb begin
    sstrb_d = sstrb_q;
    dbit_d  = dbit_q;
    if (is_mode) begin
      sstrb_d = 1'b0;
    end else if (conv_done) begin
      sstrb_d = 1'b1;
      dbit_d  = result_i[RES_W-1];
    end else if (start_p) begin
      sstrb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sstrb_q <= 1'b0;
      dbit_q  <= 1'b0;
    end else begin
      sstrb_q <= sstrb_d;
      dbit_q  <= dbit_d;
    end
  end

  assign sstrb_o   = sstrb_q;
  assign dout_o    = dbit_q;
  assign sample_o  = smp;
  assign iclk_o    = tick;
  assign mode_o    = mode_q;
  assign part_pd_o = ppd_q;
  assign full_pd_o = fpd_q;

endmodule

// File: rtl/adc_cmd_ctrl_chk.sv
module adc_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sstrb,
  input logic       sample,
  input logic       iclk,
  input logic [2:0] mode,
  input logic       ppd,
  input logic       fpd
);

  // R3: reported mode is one of the three conversion modes
  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd2);

  // R5: the two power-down states exclude each other
  a_r5_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ppd && fpd));

  // R6: no sample instant while powered down
  a_r6_no_sample_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (ppd || fpd) |-> !sample);

  // R7: strobe held low in external-clock mode
  a_r7_sstrb_low_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> !sstrb);

  // R9: internal-clock mode samples right after an internal pulse
  a_r9_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && mode == 3'd2) |-> $past(iclk));

  // R10: strobe rises two cycles after an internal pulse
  a_r10_sstrb_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb) |-> $past(iclk, 2));

  // R11: sample pulse is one cycle wide
  a_r11_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);

endmodule

bind adc_cmd_ctrl adc_cmd_ctrl_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sstrb (sstrb_o),
  .sample(sample_o),
  .iclk  (iclk_o),
  .mode  (mode_o),
  .ppd   (part_pd_o),
  .fpd   (full_pd_o)
);

// File: tb/test_adc_cmd_ctrl.sv
`timescale 1ns/1ps
module test_adc_cmd_ctrl;

  localparam int N_CH       = 4;
  localparam int RES_W      = 16;
  localparam int CONV_TICKS = 16;
  localparam int WD_CYCLES  = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic              sclk = 1'b0;
  logic              din = 1'b0;
  logic [RES_W-1:0]  result = 16'hC35A;
  logic              dout, sstrb, sample, iclk, ppd, fpd;
  logic [2:0]        mode;
  logic [3*N_CH-1:0] rng;
  logic [N_CH-1:0]   dif;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_cmd_ctrl #(.N_CH(N_CH), .RES_W(RES_W), .CONV_TICKS(CONV_TICKS)) i_adc_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .result_i(result), .dout_o(dout), .sstrb_o(sstrb), .sample_o(sample),
    .iclk_o(iclk), .mode_o(mode), .part_pd_o(ppd), .full_pd_o(fpd),
    .cfg_range_o(rng), .cfg_diff_o(dif)
  );

  // Output monitor at the falling clock edge
  int smp_cnt = 0, tick_cnt = 0, tick_at_smp = 0, tick_at_strb = 0;
  logic strb_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (iclk) tick_cnt++;
      if (sample) begin
        smp_cnt++;
        tick_at_smp = tick_cnt;
      end
      if (sstrb && !strb_prev) tick_at_strb = tick_cnt;
      strb_prev = sstrb;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sc_rise(input logic b);
    din = b; tk(4); sclk = 1'b1; tk(8);
  endtask

  task automatic sc_fall();
    sclk = 1'b0; tk(4);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin
      sc_rise(w[i]);
      sc_fall();
    end
    din = 1'b0;
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; tk(4);
  endtask

  task automatic cs_hi();
    cs_n = 1'b1; tk(6);
  endtask

  task automatic cmd(input logic [7:0] w);
    cs_lo(); send_word(w); cs_hi(); tk(4);
  endtask

  task automatic wait_strb(input int max);
    for (int i = 0; i < max && !sstrb; i++) @(negedge clk);
    tk(2);
  endtask

  // {word, mode, ppd, fpd, channel, range, diff}
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {8'h9B, 3'd0, 1'b0, 1'b0, 2'd1, 3'd5, 1'b1},
    {8'hB4, 3'd0, 1'b0, 1'b0, 2'd3, 3'd2, 1'b0},
    {8'hDF, 3'd0, 1'b0, 1'b0, 2'd1, 3'd5, 1'b1},
    {8'hE8, 3'd0, 1'b1, 1'b0, 2'd3, 3'd2, 1'b0},
    {8'h87, 3'd0, 1'b1, 1'b0, 2'd0, 3'd3, 1'b1},
    {8'hB8, 3'd0, 1'b1, 1'b0, 2'd0, 3'd3, 1'b1},
    {8'hE8, 3'd0, 1'b1, 1'b0, 2'd1, 3'd5, 1'b1},
    {8'hF8, 3'd0, 1'b0, 1'b1, 2'd1, 3'd5, 1'b1},
    {8'h98, 3'd1, 1'b0, 1'b0, 2'd1, 3'd5, 1'b1},
    {8'hD8, 3'd1, 1'b0, 1'b0, 2'd3, 3'd2, 1'b0},
    {8'hC8, 3'd0, 1'b0, 1'b0, 2'd1, 3'd1, 1'b0},
    {8'hA8, 3'd2, 1'b0, 1'b0, 2'd3, 3'd1, 1'b0},
    {8'h88, 3'd0, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0}
  };

  initial begin
    int bs, bt;
    tk(5);
    rst_n = 1'b1;
    tk(5);

    // R4: reset state
    chk(mode == 3'd0, "R4 reset mode", int'(mode), 0);
    chk(!ppd && !fpd, "R4 reset power", int'({ppd, fpd}), 0);
    chk(rng == 12'h249, "R4 reset ranges", int'(rng), 'h249);
    chk(dif == 4'h0, "R4 reset diff", int'(dif), 0);
    chk(!sstrb, "R7 reset strobe", int'(sstrb), 0);

    // Table of words: R2 R3 R4 R5 decoding and power rules
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      int ch;
      e = VEC[v];
      cmd(e[18:11]);
      ch = int'(e[5:4]);
      chk(mode == e[10:8] && ppd == e[7] && fpd == e[6] &&
          rng[3*ch +: 3] == e[3:1] && dif[ch] == e[0],
          $sformatf("R2 R3 R4 R5 word %0d", v),
          int'({mode, ppd, fpd, rng[3*ch +: 3], dif[ch]}),
          int'({e[10:6], e[3:0]}));
    end

    // R1: leading zeros skipped
    cs_lo();
    sc_rise(1'b0); sc_fall();
    sc_rise(1'b0); sc_fall();
    send_word(8'hA5);
    cs_hi(); tk(4);
    chk(rng[8:6] == 3'd2 && dif[2], "R1 leading zeros", int'({rng[8:6], dif[2]}), 5);

    // R1: partial word discarded by select rising
    cs_lo();
    sc_rise(1'b1); sc_fall();
    sc_rise(1'b1); sc_fall();
    sc_rise(1'b1); sc_fall();
    cs_hi();
    cmd(8'h98);
    chk(mode == 3'd1 && !ppd && !fpd, "R1 partial discard", int'(mode), 1);
    cmd(8'h88);

    // R7: external-clock mode sample at 8th falling edge
    bs = smp_cnt;
    cs_lo();
    for (int i = 7; i >= 1; i--) begin
      sc_rise(8'hAC >> i); sc_fall();
    end
    sc_rise(1'b0);
    chk(smp_cnt == bs, "R7 no sample before fall 8", smp_cnt - bs, 0);
    sc_fall(); tk(2);
    chk(smp_cnt == bs + 1, "R7 sample after fall 8", smp_cnt - bs, 1);
    cs_hi(); tk(40);
    chk(!sstrb, "R7 strobe low", int'(sstrb), 0);

    // R8: external-acquisition sample at 16th falling edge
    cmd(8'h98);
    bs = smp_cnt;
    cs_lo();
    send_word(8'hAC);
    for (int i = 0; i < 7; i++) begin
      sc_rise(1'b0); sc_fall();
    end
    tk(2);
    chk(smp_cnt == bs, "R8 no sample after fall 15", smp_cnt - bs, 0);
    sc_rise(1'b0); sc_fall(); tk(2);
    chk(smp_cnt == bs + 1, "R8 sample after fall 16", smp_cnt - bs, 1);
    chk(!sstrb, "R10 strobe low while converting", int'(sstrb), 0);
    wait_strb(3000);
    chk(sstrb == 1'b1, "R10 strobe rises mode 1", int'(sstrb), 1);
    chk(tick_at_strb - tick_at_smp == CONV_TICKS, "R10 conversion pulses mode 1",
        tick_at_strb - tick_at_smp, CONV_TICKS);
    chk(dout == result[RES_W-1], "R10 first result bit", int'(dout), int'(result[RES_W-1]));
    cs_hi();

    // R10: strobe stays through select low, clears on next start bit
    cs_lo(); tk(4);
    chk(sstrb == 1'b1, "R10 strobe held with select low", int'(sstrb), 1);
    sc_rise(1'b1); tk(2);
    chk(!sstrb, "R10 strobe cleared by start bit", int'(sstrb), 0);
    sc_fall();
    for (int i = 6; i >= 0; i--) begin
      sc_rise(8'hA8 >> i); sc_fall();
    end
    cs_hi(); tk(4);
    chk(mode == 3'd2, "R3 internal-clock mode set", int'(mode), 2);

    // R9: internal-clock mode, select rises right after fall 8
    bs = smp_cnt;
    bt = tick_cnt;
    cs_lo();
    send_word(8'hAC);
    cs_hi();
    wait_strb(3000);
    chk(smp_cnt == bs + 1, "R9 one sample", smp_cnt - bs, 1);
    chk(tick_at_smp - bt == 11, "R9 sample on 11th pulse", tick_at_smp - bt, 11);
    chk(tick_at_strb - tick_at_smp == CONV_TICKS, "R10 conversion pulses mode 2",
        tick_at_strb - tick_at_smp, CONV_TICKS);

    // R8: select rising before fall 16 abandons the sample
    cmd(8'h98);
    bs = smp_cnt;
    cs_lo();
    send_word(8'hAC);
    for (int i = 0; i < 5; i++) begin
      sc_rise(1'b0); sc_fall();
    end
    cs_hi(); tk(600);
    chk(smp_cnt == bs, "R8 abandoned sample", smp_cnt - bs, 0);
    chk(!sstrb, "R8 no strobe after abandon", int'(sstrb), 0);

    // R6: no conversion in full power-down
    cmd(8'hF8);
    bs = smp_cnt;
    bt = tick_cnt;
    cs_lo();
    send_word(8'hAC);
    for (int i = 0; i < 8; i++) begin
      sc_rise(1'b0); sc_fall();
    end
    cs_hi(); tk(600);
    chk(smp_cnt == bs && tick_cnt == bt, "R6 full power-down idle",
        (smp_cnt - bs) + (tick_cnt - bt), 0);

    // R5: select glitches and partial words keep partial power-down
    cmd(8'hE8);
    for (int i = 0; i < 3; i++) begin
      cs_n = 1'b0; tk(3); cs_n = 1'b1; tk(3);
    end
    cs_lo();
    sc_rise(1'b1); sc_fall();
    sc_rise(1'b0); sc_fall();
    cs_hi(); tk(10);
    chk(ppd && !fpd && mode == 3'd1, "R5 glitch keeps power-down", int'({ppd, fpd}), 2);
    cmd(8'h88);
    chk(!ppd && mode == 3'd0, "R5 exit on mode word", int'({ppd, mode}), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule